// File: doc/BRIEF.md
# Register-Mapped General-Purpose I/O Port

This block is a parameterised bank of general-purpose I/O lines controlled through a small word-wide register interface. Software writes single-cycle register accesses. Each line has an output latch and a direction bit. The block drives per-line output-enable and output-value signals towards the pad logic. It takes the per-line pad levels back through a synchroniser, so that software can read the pins.

Output levels are changed through two write-only-style registers. Writing ones to the set register raises the selected lines. Writing ones to the clear register lowers them. Zero bits leave their lines alone, so software never needs a read-modify-write. Direction can be written in either polarity, through an output-direction register or an input-direction register. Both views share one direction state, so they always read back as complements. The set register reads back the output latch. An elaboration option reverses the line-to-bit order, so that line 0 sits in the most significant register bit.

Top module: `gpio_mmio_port`

## Requirements
- R1: After reset every line is an input and every output latch is 0. pad_oe and pad_out are all zeros, the output-direction register reads 0, and the input-direction register reads 1 on every implemented line and 0 on unimplemented bits.
- R2: A read of word offset 0 (data) returns the pad_in levels as they stood two clock edges before the read is taken, after a two-stage synchroniser. Output lines are seen through the pad loopback.
- R3: A write to offset 1 (set) drives every line whose bit is 1 high. Lines whose bit is 0 keep their output value.
- R4: A write to offset 2 (clear) drives every line whose bit is 1 low. Lines whose bit is 0 keep their output value.
- R5: A write to offset 3 (output direction) makes each line with a 1 an output (pad_oe=1) and each line with a 0 an input.
- R6: A write to offset 4 (input direction) makes each line with a 1 an input and each line with a 0 an output. Offset 4 always reads as the complement of offset 3 over the implemented lines.
- R7: A read of offset 1 returns the output latch, whatever the line directions are.
- R8: With MIRROR=0, line n uses register bit n. With MIRROR=1, line n uses register bit REG_W-1-n. This holds in every register, for both reads and writes.
- R9: Writes to offset 0 or to offsets 5 to 7 change no state. Reads of offset 2, of offsets 5 to 7, and of register bits that have no line return 0.
- R10: rd_data changes only on the clock edge at which rd_en is high, and it then holds until the next read. A read taken in the same cycle as a write returns the value from before that write.
- R11: pad_out changes only on a set or clear write, and pad_oe changes only on a direction write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register word offset |
| wr_data | input | REG_W | Write data |
| rd_data | output | REG_W | Registered read data |
| pad_in | input | LINES | Pad input levels, asynchronous |
| pad_oe | output | LINES | Per-line output enable |
| pad_out | output | LINES | Per-line output value |

## Verification
The main function is exercised with single-line and multi-line set and clear patterns. These show whether zero bits really leave the other lines untouched, and whether set and clear act on the correct side of the latch. The mirrored, partially populated configuration shows whether the bit order is reversed in both directions and whether unimplemented bits read as zero. A small unmirrored instance shows the straight mapping. Direction is written through both polarities, so that any drift between the two views shows up. Pin changes are read immediately and one cycle later, which tells whether the synchroniser has exactly two stages. A long random stretch of mixed accesses is then compared cycle by cycle against a behavioural model.

// File: rtl/gpio_mmio_pkg.sv
package gpio_mmio_pkg;

  // Word offsets of the register file.
  typedef enum logic [2:0] {
    OFF_DATA   = 3'd0,
    OFF_SET    = 3'd1,
    OFF_CLR    = 3'd2,
    OFF_DIROUT = 3'd3,
    OFF_DIRIN  = 3'd4
  } reg_off_e;

  // Register bit position used by a line, with or without mirroring.
  function automatic int unsigned line_bit(int unsigned line, int unsigned reg_w, bit mirror);
    return mirror ? (reg_w - 1 - line) : line;
  endfunction

  // Line index served by a register bit (inverse of line_bit).
  function automatic int unsigned bit_line(int unsigned bitpos, int unsigned reg_w, bit mirror);
    return mirror ? (reg_w - 1 - bitpos) : bitpos;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_line_map.sv
module gpio_line_map
  import gpio_mmio_pkg::*;
#(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned LINES  = REG_W,
  parameter bit          MIRROR = 1'b0
) (
  input  logic [REG_W-1:0] reg_in,
  output logic [LINES-1:0] lines_out,
  input  logic [LINES-1:0] lines_in,
  output logic [REG_W-1:0] reg_out
);

  // Register word to line vector (write path).
  for (genvar n = 0; n < int'(LINES); n++) begin : g_to_lines
    localparam int unsigned BP = line_bit(n, REG_W, MIRROR);
    assign lines_out[n] = reg_in[BP];
  end

  // Line vector to register word (read path); bits without a line read 0.
  for (genvar b = 0; b < int'(REG_W); b++) begin : g_to_reg
    localparam int unsigned LN = bit_line(b, REG_W, MIRROR);
    if (LN < LINES) begin : g_used
      assign reg_out[b] = lines_in[LN];
    end else begin : g_empty
      assign reg_out[b] = 1'b0;
    end
  end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int unsigned LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic             wr_dirout,
  input  logic             wr_dirin,
  input  logic [LINES-1:0] wr_lines,
  output logic [LINES-1:0] out_q,
  output logic [LINES-1:0] dir_q
);

  function automatic logic [LINES-1:0] raise(logic [LINES-1:0] cur, logic [LINES-1:0] m);
    return cur | m;
  endfunction

  function automatic logic [LINES-1:0] lower(logic [LINES-1:0] cur, logic [LINES-1:0] m);
    return cur & ~m;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      if (wr_set)      out_q <= raise(out_q, wr_lines);
      else if (wr_clr) out_q <= lower(out_q, wr_lines);
      if (wr_dirout)     dir_q <= wr_lines;
      else if (wr_dirin) dir_q <= ~wr_lines;
    end
  end

endmodule

// File: rtl/gpio_mmio_port.sv
module gpio_mmio_port
  import gpio_mmio_pkg::*;
#(
  parameter int unsigned REG_W       = 32,
  parameter int unsigned LINES       = REG_W,
  parameter bit          MIRROR      = 1'b0,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic [LINES-1:0]  pad_in,
  output logic [LINES-1:0]  pad_oe,
  output logic [LINES-1:0]  pad_out
);

  // Named internal events, used by the bound checker.
  logic             wr_set_ev, wr_clr_ev, wr_dirout_ev, wr_dirin_ev;
  logic [LINES-1:0] wr_lines;
  logic [LINES-1:0] rd_lines;
  logic [LINES-1:0] pin_sync;
  logic [LINES-1:0] out_q, dir_q;
  logic [REG_W-1:0] rd_word;
  logic [REG_W-1:0] rd_q;

  assign wr_set_ev    = wr_en && (addr == ADDR_W'(OFF_SET));
  assign wr_clr_ev    = wr_en && (addr == ADDR_W'(OFF_CLR));
  assign wr_dirout_ev = wr_en && (addr == ADDR_W'(OFF_DIROUT));
  assign wr_dirin_ev  = wr_en && (addr == ADDR_W'(OFF_DIRIN));

  gpio_line_map #(.REG_W(REG_W), .LINES(LINES), .MIRROR(MIRROR)) u_map (
    .reg_in    (wr_data),
    .lines_out (wr_lines),
    .lines_in  (rd_lines),
    .reg_out   (rd_word)
  );

  gpio_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  gpio_regs #(.LINES(LINES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_set    (wr_set_ev),
    .wr_clr    (wr_clr_ev),
    .wr_dirout (wr_dirout_ev),
    .wr_dirin  (wr_dirin_ev),
    .wr_lines  (wr_lines),
    .out_q     (out_q),
    .dir_q     (dir_q)
  );

  // Read selection in line order; mapping to bit order happens in u_map.
  always_comb begin
    case (addr)
      ADDR_W'(OFF_DATA):   rd_lines = pin_sync;
      ADDR_W'(OFF_SET):    rd_lines = out_q;
      ADDR_W'(OFF_DIROUT): rd_lines = dir_q;
      ADDR_W'(OFF_DIRIN):  rd_lines = ~dir_q;
      default:             rd_lines = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_word;
  end

  assign rd_data = rd_q;
  assign pad_oe  = dir_q;
  assign pad_out = out_q;

endmodule

// File: rtl/gpio_mmio_port_chk.sv
module gpio_mmio_port_chk #(
  parameter int unsigned REG_W = 32,
  parameter int unsigned LINES = REG_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic [REG_W-1:0] rd_data,
  input logic [LINES-1:0] pad_oe,
  input logic [LINES-1:0] pad_out,
  input logic             wr_set_ev,
  input logic             wr_clr_ev,
  input logic             wr_dirout_ev,
  input logic             wr_dirin_ev,
  input logic [LINES-1:0] wr_lines
);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0 && pad_out == '0 && rd_data == '0));

  assert_set_drives_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set_ev |=> ((pad_out & $past(wr_lines)) == $past(wr_lines)));

  assert_set_keeps_others_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set_ev |=> ((pad_out & ~$past(wr_lines)) == ($past(pad_out) & ~$past(wr_lines))));

  assert_clear_drives_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr_ev |=> ((pad_out & $past(wr_lines)) == '0));

  assert_clear_keeps_others_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr_ev |=> ((pad_out & ~$past(wr_lines)) == ($past(pad_out) & ~$past(wr_lines))));

  assert_dirout_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dirout_ev |=> (pad_oe == $past(wr_lines)));

  assert_dirin_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dirin_ev |=> (pad_oe == ~$past(wr_lines)));

  assert_read_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  assert_out_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set_ev || wr_clr_ev) |=> $stable(pad_out));

  assert_oe_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_dirout_ev || wr_dirin_ev) |=> $stable(pad_oe));

endmodule

bind gpio_mmio_port gpio_mmio_port_chk #(.REG_W(REG_W), .LINES(LINES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_en        (rd_en),
  .rd_data      (rd_data),
  .pad_oe       (pad_oe),
  .pad_out      (pad_out),
  .wr_set_ev    (wr_set_ev),
  .wr_clr_ev    (wr_clr_ev),
  .wr_dirout_ev (wr_dirout_ev),
  .wr_dirin_ev  (wr_dirin_ev),
  .wr_lines     (wr_lines)
);

// File: tb/test_gpio_mmio_port.sv
`timescale 1ns/1ps
module test_gpio_mmio_port;

  localparam int RW = 16;
  localparam int NL = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]    addr = '0;
  logic [RW-1:0] wr_data = '0;
  logic [RW-1:0] rd_data;
  logic [NL-1:0] pad_in, pad_oe, pad_out;
  logic [NL-1:0] ext = '0;

  // Pad model: driven lines loop back, others follow the external level.
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_mmio_port #(.REG_W(RW), .LINES(NL), .MIRROR(1'b1)) i_gpio_mmio_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  // Small unmirrored instance.
  logic       p_wr_en = 1'b0, p_rd_en = 1'b0;
  logic [2:0] p_addr = '0;
  logic [7:0] p_wd = '0, p_rd, p_oe, p_out;
  gpio_mmio_port #(.REG_W(8), .LINES(8), .MIRROR(1'b0)) i_plain (
    .clk(clk), .rst_n(rst_n), .wr_en(p_wr_en), .rd_en(p_rd_en), .addr(p_addr),
    .wr_data(p_wd), .rd_data(p_rd), .pad_in(p_oe & p_out),
    .pad_oe(p_oe), .pad_out(p_out)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Mirrored mapping, written independently: line n <-> bit 15-n.
  function automatic logic [RW-1:0] to_reg(logic [NL-1:0] l);
    logic [RW-1:0] r = '0;
    for (int n = 0; n < NL; n++) r[RW-1-n] = l[n];
    return r;
  endfunction
  function automatic logic [NL-1:0] from_reg(logic [RW-1:0] r);
    logic [NL-1:0] l;
    for (int n = 0; n < NL; n++) l[n] = r[RW-1-n];
    return l;
  endfunction

  // Behavioural reference model.
  logic [NL-1:0] m_out, m_dir, m_s1, m_s2;
  logic [RW-1:0] m_rd;
  function automatic logic [RW-1:0] mread(logic [2:0] a);
    case (a)
      3'd0: return to_reg(m_s2);
      3'd1: return to_reg(m_out);
      3'd3: return to_reg(m_dir);
      3'd4: return to_reg(~m_dir);
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out <= '0; m_dir <= '0; m_s1 <= '0; m_s2 <= '0; m_rd <= '0;
    end else begin
      if (rd_en) m_rd <= mread(addr);
      m_s1 <= (m_dir & m_out) | (~m_dir & ext);
      m_s2 <= m_s1;
      if (wr_en) begin
        case (addr)
          3'd1: m_out <= m_out | from_reg(wr_data);
          3'd2: m_out <= m_out & ~from_reg(wr_data);
          3'd3: m_dir <= from_reg(wr_data);
          3'd4: m_dir <= ~from_reg(wr_data);
          default: ;
        endcase
      end
    end
  end

  // Every-clock comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 R4 R11 pad_out vs model", RW'(pad_out), RW'(m_out));
      chk("R5 R6 R11 pad_oe vs model", RW'(pad_oe), RW'(m_dir));
      chk("R2 R7 R10 rd_data vs model", rd_data, m_rd);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [RW-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [RW-1:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [RW-1:0] v, prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 pad_out after reset", RW'(pad_out), '0);
    chk("R1 pad_oe after reset", RW'(pad_oe), '0);
    rd(3'd3, v); chk("R1 dirout after reset", v, '0);
    rd(3'd4, v); chk("R1 dirin after reset", v, 16'hFFF0);

    // R8 mirrored mapping: bit 15 is line 0
    wr(3'd1, 16'h8000); chk("R8 R3 set line0", RW'(pad_out), 16'h0001);
    rd(3'd1, v);        chk("R7 set readback", v, 16'h8000);
    wr(3'd3, 16'h8000); chk("R5 dirout line0", RW'(pad_oe), 16'h0001);
    rd(3'd4, v);        chk("R6 dirin complement", v, 16'h7FF0);
    wr(3'd1, 16'h4000); chk("R3 zero bits keep lines", RW'(pad_out), 16'h0003);
    wr(3'd2, 16'h8000); chk("R4 clear line0 only", RW'(pad_out), 16'h0002);
    rd(3'd1, v);        chk("R7 latch of input line1", v, 16'h4000);
    wr(3'd4, 16'h0000); chk("R6 dirin zeros make outputs", RW'(pad_oe), 16'h0FFF);
    rd(3'd3, v);        chk("R6 dirout reflects dirin write", v, 16'hFFF0);

    // R9 ignored writes, zero reads
    wr(3'd0, 16'hFFFF); chk("R9 data write ignored out", RW'(pad_out), 16'h0002);
    chk("R9 data write ignored oe", RW'(pad_oe), 16'h0FFF);
    wr(3'd6, 16'hFFFF); chk("R9 unmapped write ignored", RW'(pad_out), 16'h0002);
    rd(3'd2, v); chk("R9 clear reads zero", v, '0);
    rd(3'd7, v); chk("R9 unmapped reads zero", v, '0);

    // R2 loopback of outputs, then synchroniser depth on inputs
    repeat (3) @(negedge clk);
    rd(3'd0, v); chk("R2 loopback data", v, to_reg(12'h002));
    wr(3'd3, 16'h0000);
    ext = 12'hA5C;
    repeat (4) @(negedge clk);
    rd(3'd0, v); chk("R2 input levels", v, to_reg(12'hA5C));
    ext = 12'h3C3;
    rd(3'd0, v); chk("R2 not yet through synchroniser", v, to_reg(12'hA5C));
    rd(3'd0, v); chk("R2 after two stages", v, to_reg(12'h3C3));

    // R10 hold and read-before-write
    repeat (3) @(negedge clk);
    chk("R10 rd_data holds", rd_data, to_reg(12'h3C3));
    prev = to_reg(m_out);
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; addr = 3'd1; wr_data = 16'h2000;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk("R10 read same cycle as write", rd_data, prev);

    // Random mix, compared every clock against the model
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      wr_en   = 1'($urandom);
      rd_en   = 1'($urandom);
      addr    = 3'($urandom % 8);
      wr_data = 16'($urandom);
      if ((i % 7) == 0) ext = 12'($urandom);
    end
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;

    // R8 unmirrored instance: line n is bit n
    @(negedge clk); p_wr_en = 1'b1; p_addr = 3'd1; p_wd = 8'h05;
    @(negedge clk); p_wr_en = 1'b0;
    chk("R8 plain set bit order", RW'(p_out), 16'h0005);
    @(negedge clk); p_wr_en = 1'b1; p_addr = 3'd3; p_wd = 8'h01;
    @(negedge clk); p_wr_en = 1'b0; p_rd_en = 1'b1; p_addr = 3'd4;
    @(negedge clk); p_rd_en = 1'b0;
    chk("R8 plain dirin readback", RW'(p_rd), 16'h00FE);
    chk("R5 plain dirout", RW'(p_oe), 16'h0001);

    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule